// File: doc/BRIEF.md
# Packed Halfword Saturating Adder

This block adds two 128-bit vectors as eight independent 16-bit lanes and produces the whole result in one clock cycle. A two-bit mode input selects how each lane handles overflow. In signed clamping mode, a lane result is limited to the two's-complement range. In unsigned clamping mode, a lane result is limited to the unsigned range. In the other modes the sum wraps and keeps its low sixteen bits.

The result is registered together with a valid flag and a flag that reports whether this operation clamped. A sticky status bit collects clamping events across operations. Only a write on the status port changes that bit back. A status write that lands in the same cycle as a clamping operation wins. The block sits behind an issue stage, which presents operands with a one-cycle valid strobe.

Top module: `simd_sat_adder`

## Requirements
- R1: Lane 0 is bits 127:112 of each vector and lane 7 is bits 15:0. Each result lane depends only on the same lane of the two operands.
- R2: When mode is 2'b01 (signed clamp), lanes are two's-complement. A sum above +32767 gives 16'h7FFF and a sum below -32768 gives 16'h8000. Any other sum is exact.
- R3: When mode is 2'b10 (unsigned clamp), lanes are unsigned. A sum above 65535 gives 16'hFFFF and any other sum is exact.
- R4: When mode is 2'b00 or 2'b11 (wrap), each lane is the low 16 bits of the sum and the operation never reports clamping.
- R5: The result and res_valid appear on the clock edge that samples in_valid high. res_valid is low after any edge that samples in_valid low, and res_vec then holds its last value.
- R6: res_sat is high after an operation edge exactly when at least one of the eight lanes clamped, and it is low whenever res_valid is low.
- R7: A clamping operation sets sat_sticky on the same edge. Later non-clamping operations and idle cycles leave it set.
- R8: When stat_we is high, sat_sticky takes stat_wdata on that edge, even if a clamping operation happens in the same cycle.
- R9: A synchronous active-high reset clears res_vec, res_valid, res_sat and sat_sticky.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 00/11 wrap, 01 signed clamp, 10 unsigned clamp |
| opnd_a | input | 128 | First operand, eight 16-bit lanes |
| opnd_b | input | 128 | Second operand, eight 16-bit lanes |
| stat_we | input | 1 | Status write enable |
| stat_wdata | input | 1 | Value written into the sticky bit |
| res_vec | output | 128 | Registered lane-wise result |
| res_valid | output | 1 | res_vec holds a new result |
| res_sat | output | 1 | The operation just completed clamped in some lane |
| sat_sticky | output | 1 | Accumulated clamp status |

## Verification
The only internal state beyond the output registers is the sticky bit. If it is wrong, sat_sticky is wrong on the very edge of the fault. The fault then persists through every later non-clamping operation until a status write, so the per-clock comparison catches it within one cycle. A lane-select or overflow-detect fault shows in res_vec and res_sat on the edge after the operands are presented. Extreme-value patterns in every lane position expose such a fault at once.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
    localparam int LANE_W = 16;
    localparam int LANES  = 8;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int MSB    = LANE_W - 1;

    typedef enum logic [1:0] {
        MODE_WRAP     = 2'b00,
        MODE_SCLAMP   = 2'b01,
        MODE_UCLAMP   = 2'b10,
        MODE_WRAP_ALT = 2'b11
    } add_mode_e;

    typedef struct packed {
        logic [LANE_W-1:0] val;
        logic              sat;
    } lane_res_t;

    function automatic logic [LANE_W-1:0] pos_limit();
        return {1'b0, {(LANE_W-1){1'b1}}};
    endfunction

    function automatic logic [LANE_W-1:0] neg_limit();
        return {1'b1, {(LANE_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/sat_lane_add.sv
module sat_lane_add
    import simd_sat_pkg::*;
(
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  add_mode_e         mode,
    output lane_res_t         res
);
    logic [LANE_W:0] raw;
    logic            pos_ovf;
    logic            neg_ovf;
    logic            carry;

    assign raw     = {1'b0, a} + {1'b0, b};
    assign pos_ovf = ~a[MSB] & ~b[MSB] &  raw[MSB];
    assign neg_ovf =  a[MSB] &  b[MSB] & ~raw[MSB];
    assign carry   = raw[LANE_W];

    always_comb begin
        res.val = raw[LANE_W-1:0];
        res.sat = 1'b0;
        case (mode)
            MODE_SCLAMP: begin
                if (pos_ovf) begin
                    res.val = pos_limit();
                    res.sat = 1'b1;
                end else if (neg_ovf) begin
                    res.val = neg_limit();
                    res.sat = 1'b1;
                end
            end
            MODE_UCLAMP: begin
                if (carry) begin
                    res.val = {LANE_W{1'b1}};
                    res.sat = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sat_vec_datapath.sv
module sat_vec_datapath
    import simd_sat_pkg::*;
(
    input  logic [VEC_W-1:0] va,
    input  logic [VEC_W-1:0] vb,
    input  add_mode_e        mode,
    output logic [VEC_W-1:0] vsum,
    output logic             any_sat
);
    logic [LANES-1:0] lane_sat;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HI = VEC_W - 1 - i * LANE_W;
        lane_res_t r;
        sat_lane_add u_lane (
            .a    (va[HI -: LANE_W]),
            .b    (vb[HI -: LANE_W]),
            .mode (mode),
            .res  (r)
        );
        assign vsum[HI -: LANE_W] = r.val;
        assign lane_sat[i]        = r.sat;
    end

    assign any_sat = |lane_sat;
endmodule

// File: rtl/sat_sticky_status.sv
module sat_sticky_status (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic wr_en,
    input  logic wr_data,
    output logic sticky
);
    always_ff @(posedge clk) begin
        if (rst)          sticky <= 1'b0;
        else if (wr_en)   sticky <= wr_data;
        else if (set_req) sticky <= 1'b1;
    end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       mode,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    input  logic             stat_we,
    input  logic             stat_wdata,
    output logic [VEC_W-1:0] res_vec,
    output logic             res_valid,
    output logic             res_sat,
    output logic             sat_sticky
);
    add_mode_e        mode_e;
    logic [VEC_W-1:0] sum_c;
    logic             sat_c;

    assign mode_e = add_mode_e'(mode);

    sat_vec_datapath u_dp (
        .va      (opnd_a),
        .vb      (opnd_b),
        .mode    (mode_e),
        .vsum    (sum_c),
        .any_sat (sat_c)
    );

    sat_sticky_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_req (in_valid & sat_c),
        .wr_en   (stat_we),
        .wr_data (stat_wdata),
        .sticky  (sat_sticky)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vec   <= '0;
            res_valid <= 1'b0;
            res_sat   <= 1'b0;
        end else begin
            res_valid <= in_valid;
            res_sat   <= in_valid & sat_c;
            if (in_valid) res_vec <= sum_c;
        end
    end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk
    import simd_sat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       mode,
    input logic             stat_we,
    input logic             stat_wdata,
    input logic [VEC_W-1:0] res_vec,
    input logic             res_valid,
    input logic             res_sat,
    input logic             sat_sticky
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid); // R5
    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_vec)); // R5
    AST_SAT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        res_sat |-> res_valid); // R6
    AST_WRAP_NO_SAT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mode == 2'b00 || mode == 2'b11)) |=> !res_sat); // R4
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (sat_sticky && !stat_we) |=> sat_sticky); // R7
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        !stat_we |=> (!res_sat || sat_sticky)); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> (sat_sticky == $past(stat_wdata))); // R8
endmodule

bind simd_sat_adder simd_sat_adder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .mode       (mode),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .res_vec    (res_vec),
    .res_valid  (res_valid),
    .res_sat    (res_sat),
    .sat_sticky (sat_sticky)
);

// File: tb/simd_sat_adder_bench.sv
module simd_sat_adder_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         stat_we = 1'b0;
    logic         stat_wdata = 1'b0;
    logic [127:0] res_vec;
    logic         res_valid;
    logic         res_sat;
    logic         sat_sticky;

    int errors = 0;
    int checks = 0;

    logic [127:0] m_vec = '0;
    logic         m_valid = 1'b0;
    logic         m_sat = 1'b0;
    logic         m_sticky = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_sat_adder u_simd_sat_adder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .res_vec(res_vec), .res_valid(res_valid),
        .res_sat(res_sat), .sat_sticky(sat_sticky)
    );

    // Behavioural lane sum: returns {sat, value}
    function automatic logic [16:0] ref_lane(input logic [15:0] a,
                                             input logic [15:0] b,
                                             input logic [1:0] md);
        int s;
        if (md == 2'b01) begin
            s = int'($signed(a)) + int'($signed(b));
            if (s > 32767)  return {1'b1, 16'h7FFF};
            if (s < -32768) return {1'b1, 16'h8000};
            return {1'b0, s[15:0]};
        end else if (md == 2'b10) begin
            s = int'(a) + int'(b);
            if (s > 65535) return {1'b1, 16'hFFFF};
            return {1'b0, s[15:0]};
        end
        s = int'(a) + int'(b);
        return {1'b0, s[15:0]};
    endfunction

    task automatic check1(input string tag, input string what,
                          input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, compare after the edge.
    task automatic step(input string tag, input logic r, input logic v,
                        input logic [1:0] md, input logic [127:0] a,
                        input logic [127:0] b, input logic we, input logic wd);
        logic [127:0] sum;
        logic         any;
        @(negedge clk);
        rst = r; in_valid = v; mode = md; opnd_a = a; opnd_b = b;
        stat_we = we; stat_wdata = wd;
        sum = '0; any = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic [16:0] l;
            l = ref_lane(a[127-16*i -: 16], b[127-16*i -: 16], md);
            sum[127-16*i -: 16] = l[15:0];
            any = any | l[16];
        end
        if (r) begin
            m_vec = '0; m_valid = 1'b0; m_sat = 1'b0; m_sticky = 1'b0;
        end else begin
            m_valid = v;
            m_sat = v & any;
            if (v) m_vec = sum;
            if (we) m_sticky = wd;
            else if (v && any) m_sticky = 1'b1;
        end
        @(posedge clk);
        #1;
        check1(tag, "res_valid", {127'b0, res_valid}, {127'b0, m_valid});
        check1(tag, "res_sat", {127'b0, res_sat}, {127'b0, m_sat});
        check1(tag, "sat_sticky", {127'b0, sat_sticky}, {127'b0, m_sticky});
        check1(tag, "res_vec", res_vec, m_vec);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step("R9", 1, 0, 2'b00, '0, '0, 0, 0);
        step("R9", 1, 1, 2'b01, {8{16'h7FFF}}, {8{16'h0001}}, 0, 0);
        // wrap modes
        step("R4", 0, 1, 2'b00, {8{16'hFFFF}}, {8{16'h0002}}, 0, 0);
        step("R4", 0, 1, 2'b11, {8{16'h7FFF}}, {8{16'h0001}}, 0, 0);
        // signed clamp, lane 0 positive only (R1 position)
        step("R2", 0, 1, 2'b01, {16'h7FFF, {7{16'h0010}}}, {16'h0001, {7{16'h0020}}}, 0, 0);
        step("R7", 0, 1, 2'b01, {8{16'h0003}}, {8{16'h0004}}, 0, 0);
        step("R8", 0, 0, 2'b00, '0, '0, 1, 0);
        // signed negative clamp in lane 7
        step("R1", 0, 1, 2'b01, {{7{16'hFFF0}}, 16'h8000}, {{7{16'h0001}}, 16'hFFFF}, 0, 0);
        step("R5", 0, 0, 2'b10, {8{16'hFFFF}}, {8{16'hFFFF}}, 0, 0);
        step("R5", 0, 0, 2'b01, '0, '0, 0, 0);
        step("R8", 0, 0, 2'b00, '0, '0, 1, 0);
        // unsigned clamp
        step("R3", 0, 1, 2'b10, {16'h1234, 16'hFFFF, {6{16'h8000}}}, {16'h0001, 16'h0001, {6{16'h7FFF}}}, 0, 0);
        step("R8", 0, 1, 2'b10, {8{16'hFFFF}}, {8{16'h0001}}, 1, 0);
        step("R8", 0, 0, 2'b00, '0, '0, 1, 1);
        step("R6", 0, 1, 2'b10, {8{16'h0100}}, {8{16'h0200}}, 1, 0);
        step("R2", 0, 1, 2'b01, {8{16'h8000}}, {8{16'h8000}}, 0, 0);
        for (int n = 0; n < 300; n++) begin
            logic [127:0] a, b;
            for (int k = 0; k < 4; k++) begin
                a[32*k +: 32] = $urandom;
                b[32*k +: 32] = $urandom;
            end
            step("R6", 0, ($urandom % 4) != 0, 2'($urandom), a, b,
                 ($urandom % 8) == 0, 1'($urandom));
        end
        step("R9", 1, 0, 2'b00, '0, '0, 0, 0);
        step("R9", 0, 0, 2'b00, '0, '0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule